// File: doc/BRIEF.md
# Multiplexed LED Row Scan Controller

This block scans a row-multiplexed LED display. Column bits for a row leave the block as a serial stream with its own clock, bound for an external driver chain that holds them in an internal shift register. The chain shows them on its outputs only when the block pulses a latch strobe. A binary row address selects which of the rows carries current, and a blank output switches the whole display off.

While row r is lit, the block already shifts out the bits for row r+1, so the dark time per row stays short. When that row's on-time ends and the shift is done, the block runs a fixed changeover. It blanks the display and waits a dead time so slow switches can settle. It then moves the row address, strobes the latch, and unblanks. After the last row, every frame has one extra slot in which the display stays dark.

A host writes rows into a shadow buffer at any time and then commits them. The shadow is copied into the active buffer only in that dark slot, so a frame never mixes old and new data. A busy flag shows that a committed image is still waiting for its slot.

Top module: `led_row_scan`

## Requirements
- R1: While reset is asserted, and until the first scan actions after its release, disp_blank is 1, row_sel is 0, col_strobe is 0, col_sclk is 0 and host_busy is 0.
- R2: Each row is sent as exactly COLS serial bits with bit COLS-1 first. col_sclk idles low and stays high for SCLK_HALF clock cycles per bit. col_sdata is stable across every rising edge of col_sclk.
- R3: The bits for row r+1 are clocked out while row r is lit (disp_blank 0). col_strobe is never asserted while a shift is in progress, and each strobe follows exactly COLS serial clock pulses.
- R4: Each row change follows the same order. First disp_blank rises. row_sel changes only after at least DEAD_CYCLES blanked cycles. col_strobe is then high for exactly one cycle while blanked and with the new address already present, and disp_blank falls in the cycle right after the strobe.
- R5: Rows are latched in the order 0, 1, ..., ROWS-1, then 0 again. Each row stays lit for at least ON_CYCLES consecutive cycles.
- R6: After row ROWS-1, the display stays blanked for an update slot. Before row 0 is selected again, at least ON_CYCLES+DEAD_CYCLES blanked cycles pass. The bits for row 0 are shifted during this slot, with disp_blank 1.
- R7: A host_commit pulse raises host_busy from the next cycle. In the next update slot, the shadow rows are copied into the active buffer and host_busy falls while the display is blanked. Every row latched after that carries the committed data: host_data bit i drives column bit i, and host_row selects the row.
- R8: After reset the active buffer is all zeros, so every row latched before the first commit is 0.
- R9: Writes with host_we that are not followed by host_commit do not change any latched row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_we | input | 1 | Write host_data into shadow row host_row |
| host_row | input | ROW_W | Shadow row index for a write |
| host_data | input | COLS | Column bits for the written row |
| host_commit | input | 1 | Request the shadow-to-active copy in the next update slot |
| host_busy | output | 1 | A committed image is waiting for the update slot |
| col_sdata | output | 1 | Serial column data to the driver chain |
| col_sclk | output | 1 | Serial clock to the driver chain |
| col_strobe | output | 1 | Latch strobe to the driver chain |
| disp_blank | output | 1 | 1 turns the whole display off |
| row_sel | output | ROW_W | Address of the lit row |

## Verification
The assertions assume that the parameters keep ON_CYCLES at least 3, and DEAD_CYCLES and SCLK_HALF at least 1. They also assume that the host inputs are synchronous to clk. They do not depend on when the host commits. The bench model, however, takes the swap to happen in a slot without a commit in the same cycle. The stimulus changes host inputs only on falling clock edges and uses single-cycle write and commit pulses. Each commit is issued a few cycles after a row-0 latch, far from the next update slot, and new writes are held back until host_busy has dropped.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;

  typedef enum logic [2:0] {
    SC_UPD  = 3'd0,
    SC_SEL  = 3'd1,
    SC_STB  = 3'd2,
    SC_ON   = 3'd3,
    SC_DEAD = 3'd4
  } scan_state_e;

endpackage

// File: rtl/lsc_rst_sync.sv
module lsc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_n_sync = hold_q;

endmodule

// File: rtl/lsc_frame_buf.sv
module lsc_frame_buf #(
  parameter int ROWS  = 8,
  parameter int COLS  = 16,
  parameter int ROW_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [ROW_W-1:0] host_row,
  input  logic [COLS-1:0]  host_data,
  input  logic             host_commit,
  input  logic             swap_en,
  input  logic [ROW_W-1:0] rd_row,
  output logic [COLS-1:0]  rd_data,
  output logic             busy
);

  logic [ROWS-1:0][COLS-1:0] shadow_q, shadow_d;
  logic [ROWS-1:0][COLS-1:0] active_q, active_d;
  logic                      pend_q, pend_d;

  always_comb begin
    shadow_d = shadow_q;
    active_d = active_q;
    pend_d   = pend_q;
    if (host_we) begin
      shadow_d[host_row] = host_data;
    end
    if (swap_en && pend_q) begin
      active_d = shadow_q;
      pend_d   = 1'b0;
    end
    if (host_commit) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
      pend_q   <= 1'b0;
    end else begin
      shadow_q <= shadow_d;
      active_q <= active_d;
      pend_q   <= pend_d;
    end
  end

  assign rd_data = active_q[rd_row];
  assign busy    = pend_q;

  // R7: the pending flag never drops unless the scanner opened the slot
  a_r7_drop_only_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_q) |-> $past(swap_en));

endmodule

// File: rtl/lsc_col_shift.sv
module lsc_col_shift #(
  parameter int COLS      = 16,
  parameter int SCLK_HALF = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [COLS-1:0] load_data,
  output logic            sdata,
  output logic            sclk,
  output logic            busy
);

  localparam int BW = $clog2(COLS + 1);
  localparam int DW = $clog2(SCLK_HALF + 1);

  logic [COLS-1:0] sreg_q, sreg_d;
  logic [BW-1:0]   bits_q, bits_d;
  logic [DW-1:0]   div_q, div_d;
  logic            sclk_q, sclk_d;

  always_comb begin
    sreg_d = sreg_q;
    bits_d = bits_q;
    div_d  = div_q;
    sclk_d = sclk_q;
    if (start) begin
      sreg_d = load_data;
      bits_d = BW'(COLS);
      div_d  = '0;
      sclk_d = 1'b0;
    end else if (bits_q != '0) begin
      if (div_q == DW'(SCLK_HALF - 1)) begin
        div_d = '0;
        if (!sclk_q) begin
          sclk_d = 1'b1;
        end else begin
          sclk_d = 1'b0;
          sreg_d = {sreg_q[COLS-2:0], 1'b0};
          bits_d = bits_q - 1'b1;
        end
      end else begin
        div_d = div_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      bits_q <= '0;
      div_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      sreg_q <= sreg_d;
      bits_q <= bits_d;
      div_q  <= div_d;
      sclk_q <= sclk_d;
    end
  end

  assign sdata = sreg_q[COLS-1];
  assign sclk  = sclk_q;
  assign busy  = (bits_q != '0);

  // R2: data bit does not move on the edge the driver samples
  a_r2_data_steady_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_q) |-> $stable(sreg_q[COLS-1]));

  // R2: the serial clock only toggles inside a transfer
  a_r2_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk_q);

endmodule

// File: rtl/lsc_scan_fsm.sv
module lsc_scan_fsm
  import led_scan_pkg::*;
#(
  parameter int ROWS        = 8,
  parameter int ROW_W       = 3,
  parameter int ON_CYCLES   = 400,
  parameter int DEAD_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sh_busy,
  output logic             sh_start,
  output logic [ROW_W-1:0] sh_row,
  output logic             swap_en,
  output logic [ROW_W-1:0] cur_row,
  output logic             blank,
  output logic             strobe
);

  localparam int CMAX = (ON_CYCLES > DEAD_CYCLES) ? ON_CYCLES : DEAD_CYCLES;
  localparam int CW   = $clog2(CMAX + 2);
  localparam logic [ROW_W-1:0] LAST = ROW_W'(ROWS - 1);

  scan_state_e      st_q, st_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             blank_q, strobe_q;

  always_comb begin
    st_d     = st_q;
    row_d    = row_q;
    cnt_d    = (cnt_q == {CW{1'b1}}) ? cnt_q : cnt_q + 1'b1;
    sh_start = 1'b0;
    sh_row   = '0;
    swap_en  = 1'b0;
    unique case (st_q)
      SC_UPD: begin
        swap_en  = (cnt_q == '0);
        sh_start = (cnt_q == CW'(1));
        if (cnt_q >= CW'(2) && cnt_q >= CW'(ON_CYCLES - 1) && !sh_busy) begin
          st_d  = SC_SEL;
          row_d = '0;
          cnt_d = '0;
        end
      end
      SC_SEL: begin
        st_d = SC_STB;
      end
      SC_STB: begin
        st_d  = SC_ON;
        cnt_d = '0;
      end
      SC_ON: begin
        sh_row   = row_q + 1'b1;
        sh_start = (cnt_q == '0) && (row_q != LAST);
        if (cnt_q >= CW'(1) && cnt_q >= CW'(ON_CYCLES - 1) && !sh_busy) begin
          st_d  = SC_DEAD;
          cnt_d = '0;
        end
      end
      SC_DEAD: begin
        if (cnt_q >= CW'(DEAD_CYCLES - 1)) begin
          cnt_d = '0;
          if (row_q == LAST) begin
            st_d = SC_UPD;
          end else begin
            st_d  = SC_SEL;
            row_d = row_q + 1'b1;
          end
        end
      end
      default: begin
        st_d  = SC_UPD;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= SC_UPD;
      cnt_q    <= '0;
      row_q    <= '0;
      blank_q  <= 1'b1;
      strobe_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      row_q    <= row_d;
      blank_q  <= (st_d != SC_ON);
      strobe_q <= (st_d == SC_STB);
    end
  end

  assign cur_row = row_q;
  assign blank   = blank_q;
  assign strobe  = strobe_q;

  // R5: the address only steps forward by one or wraps to row 0
  a_r5_row_steps: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(row_q) |-> (row_q == $past(row_q) + 1'b1) || (row_q == '0));

  // R4: strobe is a single-cycle pulse
  a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |=> !strobe_q);

endmodule

// File: rtl/led_row_scan.sv
module led_row_scan #(
  parameter int ROWS        = 8,
  parameter int COLS        = 16,
  parameter int SCLK_HALF   = 2,
  parameter int ON_CYCLES   = 400,
  parameter int DEAD_CYCLES = 8,
  localparam int ROW_W      = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [ROW_W-1:0] host_row,
  input  logic [COLS-1:0]  host_data,
  input  logic             host_commit,
  output logic             host_busy,
  output logic             col_sdata,
  output logic             col_sclk,
  output logic             col_strobe,
  output logic             disp_blank,
  output logic [ROW_W-1:0] row_sel
);

  logic             rst_q_n;
  logic             sh_busy;
  logic             sh_start;
  logic [ROW_W-1:0] sh_row;
  logic             swap_en;
  logic [COLS-1:0]  rd_data;

  lsc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_q_n)
  );

  lsc_frame_buf #(.ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W)) u_buf (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .host_we     (host_we),
    .host_row    (host_row),
    .host_data   (host_data),
    .host_commit (host_commit),
    .swap_en     (swap_en),
    .rd_row      (sh_row),
    .rd_data     (rd_data),
    .busy        (host_busy)
  );

  lsc_col_shift #(.COLS(COLS), .SCLK_HALF(SCLK_HALF)) u_shift (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .start     (sh_start),
    .load_data (rd_data),
    .sdata     (col_sdata),
    .sclk      (col_sclk),
    .busy      (sh_busy)
  );

  lsc_scan_fsm #(.ROWS(ROWS), .ROW_W(ROW_W), .ON_CYCLES(ON_CYCLES),
                 .DEAD_CYCLES(DEAD_CYCLES)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .sh_busy  (sh_busy),
    .sh_start (sh_start),
    .sh_row   (sh_row),
    .swap_en  (swap_en),
    .cur_row  (row_sel),
    .blank    (disp_blank),
    .strobe   (col_strobe)
  );

  // R4: latch only while dark
  a_r4_strobe_blanked: assert property (@(posedge clk) disable iff (!rst_q_n)
    col_strobe |-> disp_blank);

  // R3: no latch while bits are still travelling
  a_r3_no_strobe_mid_shift: assert property (@(posedge clk) disable iff (!rst_q_n)
    col_strobe |-> (!sh_busy && !col_sclk));

  // R4: address moves only inside a dark stretch
  a_r4_row_moves_blanked: assert property (@(posedge clk) disable iff (!rst_q_n)
    !$stable(row_sel) |-> (disp_blank && $past(disp_blank)));

  // R4: light returns only right after a latch
  a_r4_unblank_after_strobe: assert property (@(posedge clk) disable iff (!rst_q_n)
    $fell(disp_blank) |-> $past(col_strobe));

  // R7: the copy happens with the display dark
  a_r7_swap_while_dark: assert property (@(posedge clk) disable iff (!rst_q_n)
    $fell(host_busy) |-> disp_blank);

endmodule

// File: tb/tb_led_row_scan.sv
module tb_led_row_scan;

  localparam int ROWS  = 8;
  localparam int COLS  = 8;
  localparam int HALF  = 2;
  localparam int ON    = 40;
  localparam int DEAD  = 3;
  localparam int ROW_W = 3;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             host_we;
  logic [ROW_W-1:0] host_row;
  logic [COLS-1:0]  host_data;
  logic             host_commit;
  logic             host_busy;
  logic             col_sdata, col_sclk, col_strobe, disp_blank;
  logic [ROW_W-1:0] row_sel;

  always #10 clk = ~clk;

  led_row_scan #(.ROWS(ROWS), .COLS(COLS), .SCLK_HALF(HALF), .ON_CYCLES(ON),
                 .DEAD_CYCLES(DEAD)) dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_row(host_row),
    .host_data(host_data), .host_commit(host_commit), .host_busy(host_busy),
    .col_sdata(col_sdata), .col_sclk(col_sclk), .col_strobe(col_strobe),
    .disp_blank(disp_blank), .row_sel(row_sel)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  logic [COLS-1:0] mdl_shadow [ROWS];
  logic [COLS-1:0] mdl_active [ROWS];
  logic [COLS-1:0] latched    [ROWS];

  // fields: [11:9] row, [8:1] data, [0] commit
  localparam logic [11:0] VEC [7] = '{
    {3'd0, 8'hA5, 1'b0},
    {3'd3, 8'h3C, 1'b0},
    {3'd7, 8'h81, 1'b1},
    {3'd0, 8'hFF, 1'b1},
    {3'd5, 8'h0F, 1'b0},
    {3'd1, 8'hF0, 1'b1},
    {3'd7, 8'h00, 1'b1}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // monitor: bench model of the driver chain and the timing order
  logic            p_sclk, p_sdata, p_blank, p_strobe, p_busy;
  logic [ROW_W-1:0] p_row;
  logic [COLS-1:0] bsr;
  int hi_run, lit_run, blank_run, bits, exp_row, frames;

  always @(negedge clk) begin
    if (!rst_n) begin
      p_sclk = 0; p_sdata = 0; p_blank = 1; p_strobe = 0; p_busy = 0; p_row = '0;
      bsr = '0; hi_run = 0; lit_run = 0; blank_run = 0; bits = 0; exp_row = 0;
    end else begin
      if (col_sclk && !p_sclk) begin
        chk(col_sdata == p_sdata, "R2 data steady at sclk rise", col_sdata, p_sdata);
        chk(disp_blank == (exp_row == 0), "R3/R6 shift phase vs blank",
            disp_blank, exp_row == 0);
        bsr = {bsr[COLS-2:0], col_sdata};
        bits++;
      end
      if (col_sclk) hi_run++;
      if (!col_sclk && p_sclk) begin
        chk(hi_run == HALF, "R2 sclk high time", hi_run, HALF);
        hi_run = 0;
      end
      if (col_strobe) begin
        chk(disp_blank, "R4 strobe while blank", disp_blank, 1);
        chk(!p_strobe, "R4 strobe one cycle", p_strobe, 0);
        chk(bits == COLS, "R3 bits before strobe", bits, COLS);
        chk(int'(row_sel) == exp_row, "R5 row order", row_sel, exp_row);
        chk(bsr == mdl_active[row_sel], "R7 latched row data", bsr,
            mdl_active[row_sel]);
        latched[row_sel] = bsr;
        bits = 0;
        if (row_sel == '0) frames++;
        exp_row = (exp_row + 1) % ROWS;
      end
      if (row_sel != p_row) begin
        chk(disp_blank && blank_run >= DEAD, "R4 dead time before row move",
            blank_run, DEAD);
        if (row_sel == '0)
          chk(blank_run >= ON + DEAD, "R6 update slot length", blank_run, ON + DEAD);
      end
      if (!disp_blank && p_blank)
        chk(p_strobe, "R4 unblank right after strobe", p_strobe, 1);
      if (disp_blank && !p_blank)
        chk(lit_run >= ON, "R5 on time", lit_run, ON);
      if (p_busy && !host_busy) begin
        chk(disp_blank, "R7 swap while blank", disp_blank, 1);
        for (int i = 0; i < ROWS; i++) mdl_active[i] = mdl_shadow[i];
      end
      if (disp_blank) begin blank_run++; lit_run = 0; end
      else begin lit_run++; blank_run = 0; end
      p_sclk = col_sclk; p_sdata = col_sdata; p_blank = disp_blank;
      p_strobe = col_strobe; p_busy = host_busy; p_row = row_sel;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_frames(input int n);
    int target;
    target = frames + n;
    while (frames < target) @(negedge clk);
  endtask

  task automatic chk_reset_outputs(input string tag);
    chk(disp_blank == 1'b1, {tag, " blank"}, disp_blank, 1);
    chk(row_sel == '0, {tag, " row"}, row_sel, 0);
    chk(col_strobe == 1'b0, {tag, " strobe"}, col_strobe, 0);
    chk(col_sclk == 1'b0, {tag, " sclk"}, col_sclk, 0);
    chk(host_busy == 1'b0, {tag, " busy"}, host_busy, 0);
  endtask

  initial begin
    rst_n = 1'b0; host_we = 0; host_row = '0; host_data = '0; host_commit = 0;
    frames = 0;
    for (int i = 0; i < ROWS; i++) begin
      mdl_shadow[i] = '0; mdl_active[i] = '0; latched[i] = '1;
    end
    repeat (3) @(negedge clk);
    chk_reset_outputs("R1 power-on");
    rst_n = 1'b1;
    @(negedge clk);
    chk_reset_outputs("R1 after release");

    // R8: first frame shows the cleared buffer
    wait_frames(2);
    for (int i = 0; i < ROWS; i++)
      chk(latched[i] == '0, "R8 cleared after reset", latched[i], 0);

    // vector walk
    for (int v = 0; v < 7; v++) begin
      logic [ROW_W-1:0] r;
      logic [COLS-1:0]  d;
      r = VEC[v][11:9];
      d = VEC[v][8:1];
      host_we = 1; host_row = r; host_data = d;
      @(negedge clk);
      host_we = 0;
      mdl_shadow[r] = d;
      if (VEC[v][0]) begin
        host_commit = 1;
        @(negedge clk);
        host_commit = 0;
        chk(host_busy, "R7 busy after commit", host_busy, 1);
        while (host_busy) @(negedge clk);
        wait_frames(2);
        for (int i = 0; i < ROWS; i++)
          chk(latched[i] == mdl_shadow[i], "R7 committed image shown",
              latched[i], mdl_shadow[i]);
      end else begin
        wait_frames(2);
        chk(latched[r] == mdl_active[r], "R9 uncommitted write hidden",
            latched[r], mdl_active[r]);
      end
    end

    // directed: reset in the middle of a frame
    repeat (150) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk_reset_outputs("R1 mid-frame reset");
    for (int i = 0; i < ROWS; i++) begin
      mdl_shadow[i] = '0; mdl_active[i] = '0; latched[i] = '1;
    end
    @(negedge clk);
    rst_n = 1'b1;
    wait_frames(2);
    for (int i = 0; i < ROWS; i++)
      chk(latched[i] == '0, "R8 cleared after second reset", latched[i], 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule